// File: doc/BRIEF.md
# Kick-Protected Partitioned Control Register Bank

This block is a memory-mapped bank of control registers, divided into equally sized partitions that sit 0x4000 bytes apart in the address map. Each partition leaves reset in the locked state. While it is locked, writes to its ordinary registers are dropped. A bus master opens a partition by writing two magic words, one after the other, to a pair of kick registers at fixed offsets inside that partition. Each partition keeps its own lock state, and the current lock state of every partition is driven on an output vector.

The bus is a plain single-cycle register port. A write commits on the clock edge where valid and write enable are both high. Read data is a combinational function of the address. Some partition slots are left unpopulated by a parameter mask. One ordinary register, register 0 of a chosen partition, drives a two-bit network-interface mode select output.

Top module: `ctrl_part_bank`

## Requirements
- R1: After reset every partition is locked (`part_open` all zero). Ordinary registers read 0, except the mode register (partition 1, offset 0x0), which reads 0x1, so `mode_sel` is 1.
- R2: A write to an ordinary register (offsets 0x0, 0x4, 0x8, 0xC) of a locked partition leaves that register unchanged.
- R3: Writing 0x68EF3490 to kick0 (offset 0x1008) and then 0xD172BC5A to kick1 (offset 0x100C) opens the partition from the next clock edge.
- R4: A kick1 write opens the partition only if the kick write just before it, to the same partition, was the correct kick0 value. Any kick1 write clears that armed state. A wrong value at either step leaves a locked partition locked.
- R5: Partition p occupies addresses p*0x4000 and up. Kick writes to one partition change no other partition's lock state.
- R6: In an open partition, an ordinary register write takes effect at the clock edge, and a read of that register returns the written word in the same cycle as the address.
- R7: A write of any value other than 0x68EF3490 to kick0 locks the partition again. An open partition otherwise stays open until reset.
- R8: Kick registers are writable whatever the lock state. A kick0 read returns bit 0 = 1 when the partition is open and zeros elsewhere. A kick1 read returns 0.
- R9: Partitions left unpopulated by the mask (partition 6 by default) read 0 everywhere, ignore writes and never show as open. An undefined or unaligned offset inside a populated partition reads 0, and writes to it change no register.
- R10: `mode_sel` follows bits [1:0] of the mode register. Writing 0x2 selects the gigabit reduced interface only while partition 1 is open.
- R11: A write with `bus_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_we | input | 1 | Write enable, used when bus_valid is high |
| bus_addr | input | 17 | Byte address: partition index in the top bits, offset in bits [13:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| part_open | output | 8 | Per-partition unlocked flag |
| mode_sel | output | 2 | Interface mode: 1 reduced, 2 gigabit reduced |

## Verification
The assertions watch every cycle for the following:
- A partition may only become open right after a correct kick1 write to it.
- A wrong kick0 write must always close its partition.
- The mode select may only change after a write to its register while partition 1 is open.
- Unpopulated partitions and kick1 must always read zero.

Other behaviours need the bench's own scenarios, because they depend on a history of earlier accesses:
- Whether kick0 was the immediately preceding kick write.
- Whether locked writes were really dropped.
- Whether partitions stay independent of each other.

The bench covers these with a shadow model, using directed sequences and a long random mix of kick and register traffic.

// File: rtl/ctrl_part_bank.sv
module ctrl_part_bank #(
  parameter int NUM_PART  = 8,
  parameter int PART_BITS = 14,
  parameter int NREG      = 4,
  parameter int ADDR_W    = PART_BITS + $clog2(NUM_PART),
  parameter logic [NUM_PART-1:0] POP_MASK = 8'hBF,
  parameter int MODE_PART = 1,
  parameter logic [31:0] MODE_RST  = 32'h1,
  parameter logic [PART_BITS-1:0] KICK0_OFF = 14'h1008,
  parameter logic [PART_BITS-1:0] KICK1_OFF = 14'h100C,
  parameter logic [31:0] KEY0 = 32'h68EF3490,
  parameter logic [31:0] KEY1 = 32'hD172BC5A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PART-1:0] part_open,
  output logic [1:0]          mode_sel
);
  localparam int PIDX_W = ADDR_W - PART_BITS;
  localparam int RIDX_W = $clog2(NREG);

  logic [PIDX_W-1:0]    sel_part;
  logic [PART_BITS-1:0] off;
  logic                 wr, is_kick0, is_kick1, is_reg;
  logic [RIDX_W-1:0]    reg_idx;
  logic [31:0]          rd_p [NUM_PART];
  logic [1:0]           mode_word;

  assign sel_part = bus_addr[ADDR_W-1:PART_BITS];
  assign off      = bus_addr[PART_BITS-1:0];
  assign wr       = bus_valid && bus_we;
  assign is_kick0 = (off == KICK0_OFF);
  assign is_kick1 = (off == KICK1_OFF);
  assign is_reg   = (off[1:0] == 2'b00) && (32'(off[PART_BITS-1:2]) < NREG);
  assign reg_idx  = off[RIDX_W+1:2];

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    if (POP_MASK[p]) begin : g_pop
      logic        armed_q, open_q, hit;
      logic [31:0] regs_q [NREG];

      assign hit = wr && (sel_part == PIDX_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          armed_q <= 1'b0;
          open_q  <= 1'b0;
          for (int r = 0; r < NREG; r++)
            regs_q[r] <= (p == MODE_PART && r == 0) ? MODE_RST : 32'h0;
        end else if (hit) begin
          if (is_kick0) begin
            armed_q <= (bus_wdata == KEY0);
            if (bus_wdata != KEY0) open_q <= 1'b0;
          end else if (is_kick1) begin
            armed_q <= 1'b0;
            if (armed_q && bus_wdata == KEY1) open_q <= 1'b1;
          end else if (is_reg && open_q) begin
            regs_q[reg_idx] <= bus_wdata;
          end
        end
      end

      always_comb begin
        rd_p[p] = 32'h0;
        if (is_kick0)    rd_p[p] = {31'h0, open_q};
        else if (is_reg) rd_p[p] = regs_q[reg_idx];
      end

      assign part_open[p] = open_q;

      if (p == MODE_PART) begin : g_mode
        assign mode_word = regs_q[0][1:0];
      end
    end else begin : g_empty
      assign rd_p[p]      = 32'h0;
      assign part_open[p] = 1'b0;
    end
  end

  if (!POP_MASK[MODE_PART]) begin : g_nomode
    assign mode_word = MODE_RST[1:0];
  end

  assign bus_rdata = (32'(sel_part) < NUM_PART) ? rd_p[sel_part] : 32'h0;
  assign mode_sel  = mode_word;
endmodule

module part_bank_chk #(
  parameter int NUM_PART  = 8,
  parameter int PART_BITS = 14,
  parameter int ADDR_W    = 17,
  parameter logic [NUM_PART-1:0] POP_MASK = 8'hBF,
  parameter int MODE_PART = 1,
  parameter logic [31:0] MODE_RST  = 32'h1,
  parameter logic [PART_BITS-1:0] KICK0_OFF = 14'h1008,
  parameter logic [PART_BITS-1:0] KICK1_OFF = 14'h100C,
  parameter logic [31:0] KEY0 = 32'h68EF3490,
  parameter logic [31:0] KEY1 = 32'hD172BC5A
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_valid,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PART-1:0] part_open,
  input logic [1:0]          mode_sel
);
  localparam int PIDX_W = ADDR_W - PART_BITS;
  logic [PIDX_W-1:0]    c_part;
  logic [PART_BITS-1:0] c_off;
  logic                 c_wr;
  assign c_part = bus_addr[ADDR_W-1:PART_BITS];
  assign c_off  = bus_addr[PART_BITS-1:0];
  assign c_wr   = bus_valid && bus_we;

  a_r1_reset_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (part_open == '0 && mode_sel == MODE_RST[1:0]));

  for (genvar p = 0; p < NUM_PART; p++) begin : g_chk
    a_r3_open_needs_kick1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(part_open[p]) |->
        $past(c_wr && c_part == PIDX_W'(p) && c_off == KICK1_OFF && bus_wdata == KEY1));
    a_r7_bad_kick0_locks: assert property (@(posedge clk) disable iff (!rst_n)
      (c_wr && c_part == PIDX_W'(p) && c_off == KICK0_OFF && bus_wdata != KEY0)
        |=> !part_open[p]);
  end

  a_r10_mode_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != $past(mode_sel)) |->
      $past(c_wr && c_part == PIDX_W'(MODE_PART) && c_off == '0 && part_open[MODE_PART]));

  a_r9_unpop_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !POP_MASK[c_part]) |-> bus_rdata == 32'h0);

  a_r8_kick1_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && c_off == KICK1_OFF) |-> bus_rdata == 32'h0);
endmodule

bind ctrl_part_bank part_bank_chk #(
  .NUM_PART(NUM_PART), .PART_BITS(PART_BITS), .ADDR_W(ADDR_W), .POP_MASK(POP_MASK),
  .MODE_PART(MODE_PART), .MODE_RST(MODE_RST), .KICK0_OFF(KICK0_OFF),
  .KICK1_OFF(KICK1_OFF), .KEY0(KEY0), .KEY1(KEY1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .part_open(part_open), .mode_sel(mode_sel)
);

// File: tb/tb_ctrl_part_bank.sv
`timescale 1ns/1ps
module tb_ctrl_part_bank;
  localparam logic [31:0] K0 = 32'h68EF3490;
  localparam logic [31:0] K1 = 32'hD172BC5A;
  localparam logic [7:0]  POP = 8'hBF;

  logic clk = 0, rst_n = 0, bus_valid = 0, bus_we = 0;
  logic [16:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  part_open;
  logic [1:0]  mode_sel;
  int total = 0, fails = 0;

  logic [31:0] m_reg [8][4];
  logic [7:0]  m_open, m_armed;

  ctrl_part_bank dut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .part_open(part_open), .mode_sel(mode_sel));

  always #10 clk = ~clk;

  function automatic logic [16:0] ad(int p, logic [13:0] o);
    return {p[2:0], o};
  endfunction

  function automatic logic [31:0] exp_rd(logic [16:0] a);
    logic [2:0] p = a[16:14];
    logic [13:0] o = a[13:0];
    if (!POP[p]) return 32'h0;
    if (o == 14'h1008) return {31'h0, m_open[p]};
    if (o[1:0] == 2'b00 && o < 14'h10) return m_reg[p][o[3:2]];
    return 32'h0;
  endfunction

  task automatic model_wr(logic [16:0] a, logic [31:0] d);
    logic [2:0] p = a[16:14];
    logic [13:0] o = a[13:0];
    if (!POP[p]) return;
    if (o == 14'h1008) begin
      m_armed[p] = (d == K0);
      if (d != K0) m_open[p] = 1'b0;
    end else if (o == 14'h100C) begin
      if (m_armed[p] && d == K1) m_open[p] = 1'b1;
      m_armed[p] = 1'b0;
    end else if (o[1:0] == 2'b00 && o < 14'h10 && m_open[p]) m_reg[p][o[3:2]] = d;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [16:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(string req, logic [16:0] a);
    @(negedge clk);
    bus_valid = 1; bus_we = 0; bus_addr = a;
    #1 chk(req, bus_rdata, exp_rd(a));
    bus_valid = 0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240));
    m_open = '0; m_armed = '0;
    for (int p = 0; p < 8; p++)
      for (int r = 0; r < 4; r++) m_reg[p][r] = (p == 1 && r == 0) ? 32'h1 : 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 part_open", {24'h0, part_open}, 32'h0);
    chk("R1 mode_sel", {30'h0, mode_sel}, 32'h1);
    rd_chk("R1 mode reg", ad(1, 14'h0));
    rd_chk("R1 kick0 locked", ad(1, 14'h1008));

    wr(ad(0, 14'h4), 32'hDEADBEEF);
    rd_chk("R2 locked write dropped", ad(0, 14'h4));
    wr(ad(1, 14'h0), 32'h2);
    chk("R10 locked mode write", {30'h0, mode_sel}, 32'h1);

    wr(ad(1, 14'h100C), K1);
    chk("R4 kick1 alone", {31'h0, part_open[1]}, 32'h0);
    wr(ad(1, 14'h1008), K0);
    wr(ad(1, 14'h100C), 32'h12345678);
    wr(ad(1, 14'h100C), K1);
    chk("R4 wrong kick1 resets sequence", {31'h0, part_open[1]}, 32'h0);

    wr(ad(1, 14'h1008), K0);
    wr(ad(1, 14'h100C), K1);
    chk("R3 unlock", {24'h0, part_open}, 32'h2);
    rd_chk("R8 kick0 reads open", ad(1, 14'h1008));
    rd_chk("R8 kick1 reads zero", ad(1, 14'h100C));
    wr(ad(0, 14'h4), 32'hCAFEF00D);
    rd_chk("R5 other partition still locked", ad(0, 14'h4));
    wr(ad(1, 14'h0), 32'h2);
    chk("R10 mode gigabit", {30'h0, mode_sel}, 32'h2);
    wr(ad(1, 14'hC), 32'hA5A55A5A);
    rd_chk("R6 readback", ad(1, 14'hC));

    @(negedge clk);
    bus_valid = 0; bus_we = 1; bus_addr = ad(1, 14'hC); bus_wdata = 32'h0BADF00D;
    @(negedge clk); bus_we = 0;
    rd_chk("R11 valid low ignored", ad(1, 14'hC));

    wr(ad(1, 14'h20), 32'h77);
    rd_chk("R9 undefined offset reads zero", ad(1, 14'h20));
    wr(ad(1, 14'h2), 32'h3);
    chk("R9 unaligned write ignored", {30'h0, mode_sel}, 32'h2);

    wr(ad(1, 14'h1008), 32'h0);
    chk("R7 relock", {31'h0, part_open[1]}, 32'h0);
    wr(ad(1, 14'h8), 32'h99);
    rd_chk("R7 write after relock dropped", ad(1, 14'h8));

    wr(ad(6, 14'h1008), K0);
    wr(ad(6, 14'h100C), K1);
    chk("R9 unpopulated never opens", {31'h0, part_open[6]}, 32'h0);
    wr(ad(6, 14'h0), 32'h55);
    rd_chk("R9 unpopulated reads zero", ad(6, 14'h0));

    for (int i = 0; i < 3000; i++) begin
      int p = $urandom % 8;
      int k = $urandom % 6;
      logic [13:0] o = 14'($urandom % 6) << 2;
      logic [31:0] d = $urandom;
      case (k)
        0: begin
             wr(ad(p, 14'h1008), K0);
             if ($urandom % 2) wr(ad(p, 14'h100C), K1);
           end
        1: wr(ad(p, 14'h1008), ($urandom % 4 == 0) ? K0 : d);
        2: wr(ad(p, 14'h100C), K1);
        3: wr(ad(p, 14'h100C), d);
        4: wr(ad(p, o), d);
        default: ;
      endcase
      rd_chk("R6 random readback", ad(p, o));
      rd_chk("R8 random kick0", ad(p, 14'h1008));
      chk("R5 random part_open", {24'h0, part_open}, {24'h0, m_open});
      chk("R10 random mode_sel", {30'h0, mode_sel}, {30'h0, m_reg[1][0][1:0]});
    end
    finish_run();
  end
endmodule